// File: doc/BRIEF.md
# Three-Wire Codec Control Bus Master

This block drives a three-wire serial control bus (clock, data, mode) of the kind used to configure audio codecs. A host places a device address, a register-class selector, a byte count, write data and a read/write flag on its inputs, then pulses a start request. The block runs one address phase and then up to `MAX_BYTES` data phases. All timing is set in system-clock cycles by five inputs: clock-low, clock-high, setup, hold and halt.

The address phase runs with the bus clock held low through its setup interval. The first data byte starts without a gap. Every later data byte is preceded by a halt pulse on the clock line. Bits travel least significant first. On a read, the master releases the data line after the address byte, samples one bit per clock and returns the collected bytes on a parallel output.

Top module: `cw3_master`

## Requirements
- R1: After reset and whenever idle, busClk, busData and busMode are 0, busDataOe is 1, and busy, done and rdValid are 0.
- R2: In the cycle after startReq is sampled while idle, busy is 1 and busClk, busData and busMode are all 1 with busDataOe 1. This start cycle lasts exactly one cycle.
- R3: The address byte is {devAddr[5:0], regClass[1:0]} (regClass in bits 1:0), sent bit 0 first. During its setup interval busClk is 0 and busData is 1.
- R4: Each bit is sent as a low interval followed by a high interval. The low interval lasts lowCycles cycles with busClk 0. The high interval lasts highCycles cycles with busClk 1. busData carries the bit through both intervals, and a value of 0 in any timing input counts as 1 cycle. Write data byte k (k from 1) is wrData[8k-1:8k-8], sent bit 0 first.
- R5: Before each byte's bits there is a setup interval of setupCycles, and after them a hold interval of holdCycles. busClk is 1 in both intervals, except for the address setup (R3). busData is 1 in both intervals while the block drives the line.
- R6: The first data byte follows the address hold directly. Each later data byte is preceded by a halt interval of haltCycles with busClk 0, followed by its setup interval with busClk 1.
- R7: On a read (rdNotWr=1), busDataOe and busData are 0 through every data-byte phase, and busDataIn is sampled in the last cycle of each low interval. One cycle after done, rdValid pulses for one cycle and rdData holds byte k at bits [8k-1:8k-8], assembled bit 0 first. Bytes beyond the count read as 0.
- R8: When the last hold interval ends, busy drops and done is 1 for exactly one cycle. In that cycle all three bus lines are 0.
- R9: A startReq that arrives while busy is ignored. It neither changes the running transaction nor queues a new one.
- R10: A byte count of 0 sends only the address phase. A count above MAX_BYTES is treated as MAX_BYTES.
- R11: busMode is 1 for the whole time busy is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start a transaction (sampled while idle) |
| rdNotWr | input | 1 | 1 = read data phases, 0 = write |
| devAddr | input | 6 | Device address, upper six bits of the address byte |
| regClass | input | 2 | Register-class selector, low two bits of the address byte |
| byteCount | input | 2 | Number of data bytes (0 to MAX_BYTES) |
| wrData | input | 16 | Write bytes, byte 1 in bits 7:0 |
| lowCycles | input | 8 | Clock-low time per bit |
| highCycles | input | 8 | Clock-high time per bit |
| setupCycles | input | 8 | Interval before each byte's bits |
| holdCycles | input | 8 | Interval after each byte's bits |
| haltCycles | input | 8 | Clock-low halt before data bytes 2 and later |
| busDataIn | input | 1 | Data line value seen from the bus |
| busClk | output | 1 | Bus clock |
| busData | output | 1 | Data line drive value |
| busDataOe | output | 1 | Data line output enable |
| busMode | output | 1 | Bus mode line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rdData | output | 16 | Read bytes, byte 1 in bits 7:0 |
| rdValid | output | 1 | rdData valid pulse, one cycle after done |

## Verification
The bus lines follow a fixed schedule that starts one cycle after the start request is taken. That cycle is followed by the setup, bit-low, bit-high, hold and halt intervals, each max(n,1) cycles long. done is due one cycle after the last hold cycle, and rdValid one cycle after done. The bench builds this schedule from the timing inputs and byte count, then compares every bus line, busy and done at each falling edge for the full length of the transaction. Read bits are driven to the expected value only in the last cycle of each low interval and to the inverse value in every other cycle. This proves that the sample point falls exactly there. An extra start request is injected in the middle of a transaction, and the schedule must continue unchanged.

// File: rtl/cw3_pkg.sv
package cw3_pkg;
  localparam int BYTE_W  = 8;
  localparam int DEV_W   = 6;
  localparam int CLASS_W = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_SETUP, S_BITLO, S_BITHI, S_HOLD, S_HALT, S_FINISH
  } cw3_state_e;

  typedef struct packed {
    logic capture;
    logic loadByte;
    logic shiftBit;
    logic sampleBit;
    logic storeByte;
    logic publish;
  } cw3_strobe_t;
endpackage

// File: rtl/cw3_control.sv
module cw3_control
  import cw3_pkg::*;
#(
  parameter int MAX_BYTES = 2,
  parameter int TIME_W    = 8,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              rdNotWr,
  input  logic [IDX_W-1:0]  byteCount,
  input  logic [TIME_W-1:0] lowCycles,
  input  logic [TIME_W-1:0] highCycles,
  input  logic [TIME_W-1:0] setupCycles,
  input  logic [TIME_W-1:0] holdCycles,
  input  logic [TIME_W-1:0] haltCycles,
  output cw3_strobe_t       strb,
  output logic [IDX_W-1:0]  curIdx,
  output logic [IDX_W-1:0]  nextIdx,
  output logic              bitPhase,
  output logic              busClk,
  output logic              busMode,
  output logic              busDataOe,
  output logic              busy,
  output logic              done
);
  localparam logic [IDX_W-1:0] MAXI = IDX_W'(MAX_BYTES);

  cw3_state_e        state;
  logic [TIME_W-1:0] tmr;
  logic [2:0]        bitIdx;
  logic [IDX_W-1:0]  byteIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic              readLat;
  logic              tmrDone;

  function automatic logic [TIME_W-1:0] span(input logic [TIME_W-1:0] n);
    return (n == '0) ? '0 : n - TIME_W'(1);
  endfunction

  assign tmrDone = (tmr == '0);
  assign curIdx  = byteIdx;
  assign nextIdx = (state == S_START) ? '0 : byteIdx + IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      tmr     <= '0;
      bitIdx  <= '0;
      byteIdx <= '0;
      lastIdx <= '0;
      readLat <= 1'b0;
    end else if (state == S_IDLE) begin
      if (startReq) begin
        state   <= S_START;
        readLat <= rdNotWr;
        lastIdx <= (byteCount > MAXI) ? MAXI : byteCount;
        byteIdx <= '0;
        tmr     <= '0;
      end
    end else if (!tmrDone) begin
      tmr <= tmr - TIME_W'(1);
    end else begin
      case (state)
        S_START: begin
          state <= S_SETUP;
          tmr   <= span(setupCycles);
        end
        S_SETUP: begin
          state  <= S_BITLO;
          bitIdx <= '0;
          tmr    <= span(lowCycles);
        end
        S_BITLO: begin
          state <= S_BITHI;
          tmr   <= span(highCycles);
        end
        S_BITHI: begin
          if (bitIdx == 3'd7) begin
            state <= S_HOLD;
            tmr   <= span(holdCycles);
          end else begin
            bitIdx <= bitIdx + 3'd1;
            state  <= S_BITLO;
            tmr    <= span(lowCycles);
          end
        end
        S_HOLD: begin
          if (byteIdx == lastIdx) begin
            state <= S_FINISH;
          end else begin
            byteIdx <= byteIdx + IDX_W'(1);
            if (byteIdx == '0) begin
              state <= S_SETUP;
              tmr   <= span(setupCycles);
            end else begin
              state <= S_HALT;
              tmr   <= span(haltCycles);
            end
          end
        end
        S_HALT: begin
          state <= S_SETUP;
          tmr   <= span(setupCycles);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb           = '0;
    strb.capture   = (state == S_IDLE) && startReq;
    strb.loadByte  = (state == S_START) ||
                     (state == S_HOLD && tmrDone && byteIdx != lastIdx);
    strb.shiftBit  = (state == S_BITHI) && tmrDone;
    strb.sampleBit = (state == S_BITLO) && tmrDone && readLat && byteIdx != '0;
    strb.storeByte = (state == S_HOLD) && tmrDone && readLat && byteIdx != '0;
    strb.publish   = (state == S_FINISH) && readLat;
  end

  assign busy      = (state != S_IDLE) && (state != S_FINISH);
  assign done      = (state == S_FINISH);
  assign bitPhase  = (state == S_BITLO) || (state == S_BITHI);
  assign busMode   = busy;
  assign busClk    = busy && !(state == S_HALT || state == S_BITLO ||
                               (state == S_SETUP && byteIdx == '0));
  assign busDataOe = !(busy && readLat && byteIdx != '0);

  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: busy falling is always accompanied by done
  a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  // R9: a request while busy leaves the latched transaction untouched
  a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> ($stable(lastIdx) && $stable(readLat)));
  // R6: halt intervals only precede data bytes two and later
  a_r6_halt_late_only: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HALT) |-> (byteIdx >= IDX_W'(2)));
  // R4: after the eighth bit high interval, the hold interval follows
  a_r4_eight_bits: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BITHI && tmrDone && bitIdx == 3'd7) |=> (state == S_HOLD));
  // R10: a transaction never runs past the clamped byte count
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (byteIdx <= lastIdx && lastIdx <= MAXI));
endmodule

// File: rtl/cw3_datapath.sv
module cw3_datapath
  import cw3_pkg::*;
#(
  parameter int MAX_BYTES = 2,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1),
  localparam int DEPTH    = 2 ** IDX_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  cw3_strobe_t                 strb,
  input  logic [IDX_W-1:0]            curIdx,
  input  logic [IDX_W-1:0]            nextIdx,
  input  logic [DEV_W-1:0]            devAddr,
  input  logic [CLASS_W-1:0]          regClass,
  input  logic [BYTE_W*MAX_BYTES-1:0] wrData,
  input  logic                        busDataIn,
  input  logic                        busy,
  input  logic                        bitPhase,
  input  logic                        busDataOe,
  output logic                        busData,
  output logic [BYTE_W*MAX_BYTES-1:0] rdData,
  output logic                        rdValid
);
  logic [BYTE_W-1:0] addrLat;
  logic [BYTE_W-1:0] wrLat [DEPTH];
  logic [BYTE_W-1:0] rxBuf [DEPTH];
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] rxShift;
  logic [IDX_W-1:0]  loadSel;
  logic [IDX_W-1:0]  storeSel;

  assign loadSel  = nextIdx - IDX_W'(1);
  assign storeSel = curIdx - IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat <= '0;
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        wrLat[i] <= '0;
        rxBuf[i] <= '0;
      end
    end else begin
      rdValid <= 1'b0;
      if (strb.capture) begin
        addrLat <= {devAddr, regClass};
        for (int i = 0; i < DEPTH; i++) begin
          wrLat[i] <= (i < MAX_BYTES) ? wrData[BYTE_W*i +: BYTE_W] : '0;
          rxBuf[i] <= '0;
        end
      end
      if (strb.loadByte)
        txShift <= (nextIdx == '0) ? addrLat : wrLat[loadSel];
      else if (strb.shiftBit)
        txShift <= {1'b1, txShift[BYTE_W-1:1]};
      if (strb.sampleBit)
        rxShift <= {busDataIn, rxShift[BYTE_W-1:1]};
      if (strb.storeByte)
        rxBuf[storeSel] <= rxShift;
      if (strb.publish) begin
        rdValid <= 1'b1;
        for (int k = 0; k < MAX_BYTES; k++)
          rdData[BYTE_W*k +: BYTE_W] <= rxBuf[k];
      end
    end
  end

  assign busData = busy && busDataOe && (bitPhase ? txShift[0] : 1'b1);

  // R7: rdValid is a single-cycle pulse
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);
  // R7: the data line is never driven high while released
  a_r7_released_low: assert property (@(posedge clk) disable iff (!rstN)
    !busDataOe |-> !busData);
  // R7: read data is held until the next publish
  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.publish) |-> $stable(rdData));
endmodule

// File: rtl/cw3_master.sv
module cw3_master
  import cw3_pkg::*;
#(
  parameter int MAX_BYTES = 2,
  parameter int TIME_W    = 8,
  localparam int IDX_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startReq,
  input  logic                        rdNotWr,
  input  logic [DEV_W-1:0]            devAddr,
  input  logic [CLASS_W-1:0]          regClass,
  input  logic [IDX_W-1:0]            byteCount,
  input  logic [BYTE_W*MAX_BYTES-1:0] wrData,
  input  logic [TIME_W-1:0]           lowCycles,
  input  logic [TIME_W-1:0]           highCycles,
  input  logic [TIME_W-1:0]           setupCycles,
  input  logic [TIME_W-1:0]           holdCycles,
  input  logic [TIME_W-1:0]           haltCycles,
  input  logic                        busDataIn,
  output logic                        busClk,
  output logic                        busData,
  output logic                        busDataOe,
  output logic                        busMode,
  output logic                        busy,
  output logic                        done,
  output logic [BYTE_W*MAX_BYTES-1:0] rdData,
  output logic                        rdValid
);
  cw3_strobe_t      strb;
  logic [IDX_W-1:0] curIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             bitPhase;

  cw3_control #(.MAX_BYTES(MAX_BYTES), .TIME_W(TIME_W)) u_control (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rdNotWr(rdNotWr),
    .byteCount(byteCount), .lowCycles(lowCycles), .highCycles(highCycles),
    .setupCycles(setupCycles), .holdCycles(holdCycles), .haltCycles(haltCycles),
    .strb(strb), .curIdx(curIdx), .nextIdx(nextIdx), .bitPhase(bitPhase),
    .busClk(busClk), .busMode(busMode), .busDataOe(busDataOe),
    .busy(busy), .done(done)
  );

  cw3_datapath #(.MAX_BYTES(MAX_BYTES)) u_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .curIdx(curIdx), .nextIdx(nextIdx),
    .devAddr(devAddr), .regClass(regClass), .wrData(wrData),
    .busDataIn(busDataIn), .busy(busy), .bitPhase(bitPhase),
    .busDataOe(busDataOe), .busData(busData), .rdData(rdData), .rdValid(rdValid)
  );

  // R4: the data line holds still while the clock is high inside a bit
  a_r4_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (bitPhase && busClk && $past(bitPhase && busClk)) |-> $stable(busData));
  // R11: mode is high throughout a transaction
  a_r11_mode_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (busMode && $past(busMode)));
  // R1: idle outputs are quiet
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> (!busClk && !busData && !busMode && busDataOe));
endmodule

// File: tb/cw3_master_bench.sv
module cw3_master_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic        rdNotWr = 1'b0;
  logic [5:0]  devAddr = '0;
  logic [1:0]  regClass = '0;
  logic [1:0]  byteCount = '0;
  logic [15:0] wrData = '0;
  logic [7:0]  lowCycles = 8'd1, highCycles = 8'd1, setupCycles = 8'd1;
  logic [7:0]  holdCycles = 8'd1, haltCycles = 8'd1;
  logic        busDataIn = 1'b0;
  logic        busClk, busData, busDataOe, busMode, busy, done, rdValid;
  logic [15:0] rdData;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cw3_master u_cw3_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rdNotWr(rdNotWr),
    .devAddr(devAddr), .regClass(regClass), .byteCount(byteCount),
    .wrData(wrData), .lowCycles(lowCycles), .highCycles(highCycles),
    .setupCycles(setupCycles), .holdCycles(holdCycles), .haltCycles(haltCycles),
    .busDataIn(busDataIn), .busClk(busClk), .busData(busData),
    .busDataOe(busDataOe), .busMode(busMode), .busy(busy), .done(done),
    .rdData(rdData), .rdValid(rdValid)
  );

  function automatic int dur(input logic [7:0] n);
    return (n == 0) ? 1 : int'(n);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (!ok) begin
      missCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compares {clk,data,oe,mode,busy,done} for n cycles at falling edges
  task automatic seg(input int n, input bit c, input bit d, input bit oe,
                     input string req);
    for (int i = 0; i < n; i++) begin
      logic [5:0] act, exp;
      act = {busClk, busData, busDataOe, busMode, busy, done};
      exp = {c, d, oe, 1'b1, 1'b1, 1'b0};
      check(act == exp, req, "bus lines", 32'(act), 32'(exp));
      @(negedge clk);
    end
  endtask

  task automatic runTxn(input bit rw, input logic [5:0] da, input logic [1:0] rc,
                        input int cnt, input logic [15:0] wd,
                        input logic [15:0] rx, input bit poke);
    int n;
    logic [15:0] expRd;
    n = (cnt > 2) ? 2 : cnt;
    expRd = '0;
    @(negedge clk);
    rdNotWr = rw; devAddr = da; regClass = rc;
    byteCount = 2'(cnt); wrData = wd; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (poke) begin
      fork
        begin
          repeat (6) @(negedge clk);
          startReq = 1'b1; devAddr = ~da; regClass = ~rc;
          rdNotWr = ~rw; byteCount = 2'd0; wrData = ~wd;
          @(negedge clk);
          startReq = 1'b0;
        end
      join_none
    end
    seg(1, 1'b1, 1'b1, 1'b1, "R2");
    for (int b = 0; b <= n; b++) begin
      bit rdPh;
      bit oe;
      logic [7:0] val;
      logic [7:0] rxb;
      rdPh = rw && (b > 0);
      oe = !rdPh;
      val = (b == 0) ? {da, rc} : wd[8*(b-1) +: 8];
      rxb = (b == 0) ? 8'h00 : rx[8*(b-1) +: 8];
      if (b > 0 && rw) expRd[8*(b-1) +: 8] = rxb;
      if (b >= 2) seg(dur(haltCycles), 1'b0, oe, oe, "R6");
      seg(dur(setupCycles), (b == 0) ? 1'b0 : 1'b1, oe, oe, (b == 0) ? "R3" : "R5");
      for (int i = 0; i < 8; i++) begin
        bit bv;
        bv = oe ? val[i] : 1'b0;
        for (int c = 0; c < dur(lowCycles); c++) begin
          busDataIn = (c == dur(lowCycles) - 1) ? rxb[i] : ~rxb[i];
          seg(1, 1'b0, bv, oe, (b == 0) ? "R3" : (rdPh ? "R7" : "R4"));
        end
        busDataIn = ~rxb[i];
        seg(dur(highCycles), 1'b1, bv, oe, (b == 0) ? "R3" : "R4");
      end
      seg(dur(holdCycles), 1'b1, oe, oe, "R5");
    end
    // finish cycle
    check({busy, done, busClk, busData, busMode} == 5'b01000, "R8",
          "done cycle", 32'({busy, done, busClk, busData, busMode}), 32'h8);
    @(negedge clk);
    check(!done, "R8", "done single pulse", 32'(done), 0);
    check(rdValid == rw, "R7", "rdValid one cycle after done", 32'(rdValid), 32'(rw));
    if (rw) check(rdData == expRd, "R7", "read bytes", 32'(rdData), 32'(expRd));
    check({busClk, busData, busMode, busDataOe, busy} == 5'b00010, "R1",
          "idle lines", 32'({busClk, busData, busMode, busDataOe, busy}), 32'h2);
    @(negedge clk);
    check(!busy && !rdValid, poke ? "R9" : "R1", "no queued transaction",
          32'({busy, rdValid}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check({busClk, busData, busMode, busDataOe, busy, done, rdValid} == 7'b0001000,
          "R1", "reset state",
          32'({busClk, busData, busMode, busDataOe, busy, done, rdValid}), 32'h8);
    rstN = 1'b1;
    @(negedge clk);
    // directed: R10 zero count sends address only
    runTxn(1'b0, 6'h25, 2'b10, 0, 16'h0000, 16'h0000, 1'b0);
    // directed: two write bytes with halt, R6
    setupCycles = 8'd2; holdCycles = 8'd3; haltCycles = 8'd4;
    lowCycles = 8'd2; highCycles = 8'd3;
    runTxn(1'b0, 6'h05, 2'b00, 2, 16'hC3A5, 16'h0000, 1'b0);
    // directed: R10 count above maximum clamps to two
    runTxn(1'b0, 6'h3F, 2'b11, 3, 16'h0F81, 16'h0000, 1'b0);
    // directed: read of two bytes with zero timings (count as one), R7
    setupCycles = 8'd0; holdCycles = 8'd0; haltCycles = 8'd0;
    lowCycles = 8'd0; highCycles = 8'd0;
    runTxn(1'b1, 6'h14, 2'b01, 2, 16'h0000, 16'h5AC3, 1'b0);
    // directed: R9 start request mid-transaction is ignored
    lowCycles = 8'd3; highCycles = 8'd2;
    runTxn(1'b1, 6'h2A, 2'b10, 1, 16'h0000, 16'h00E7, 1'b1);
    runTxn(1'b0, 6'h11, 2'b01, 2, 16'h6699, 16'h0000, 1'b1);
    // random mix
    for (int r = 0; r < 30; r++) begin
      lowCycles   = 8'($urandom_range(0, 4));
      highCycles  = 8'($urandom_range(0, 4));
      setupCycles = 8'($urandom_range(0, 4));
      holdCycles  = 8'($urandom_range(0, 4));
      haltCycles  = 8'($urandom_range(0, 5));
      runTxn(1'($urandom), 6'($urandom), 2'($urandom), int'($urandom_range(0, 3)),
             16'($urandom), 16'($urandom), 1'($urandom));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule